// File: doc/BRIEF.md
# Packed Parallel Sample Port

This block lets a processor or DMA engine feed a filter channel with signed 16-bit samples through a memory-mapped word, instead of the channel taking a serial bitstream. The word holds two signed sample fields: a low field in bits 15:0 and a high field in bits 31:16. A write bus with one strobe per byte lane updates the word. A packing mode then decides how the newly written word becomes filter samples. It can yield one sample, two samples in turn on the channel's own port, or one sample on the channel's own port and one on the port of a paired neighbour channel.

Each output port is a registered valid/ready pair that holds its sample until the filter takes it. The source select tells the block whether the channel runs from parallel data. If it does not, the block drops every write. A write that arrives while any sample from an earlier write is still waiting is also dropped, and it raises a sticky overrun flag.

Top module: `par_sample_port`

## Requirements
- R1: After reset both valid outputs are 0, both sample outputs are 0, the overrun flag is 0 and the stored word is all zeros.
- R2: Writes take effect only when `src_sel` is 2'b10 (parallel source). With any other value a write changes neither the stored word nor the outputs.
- R3: In standard mode (`pack_mode` 2'b00) byte lanes 2 and 3 are write-protected. A write that strobes lane 0 or lane 1 produces exactly one sample on the main port, equal to bits 15:0 of the updated word. A write that strobes only the upper lanes produces no sample.
- R4: Only the byte lanes whose `wr_strb` bit is set are updated; the other lanes keep their stored bytes.
- R5: In interleaved mode (2'b01) a write with any strobe set produces two samples on the main port: bits 15:0 first, then bits 31:16. The second sample is presented in the cycle after the first is consumed. The neighbour port stays idle.
- R6: In dual mode (2'b10) a write with any strobe set presents bits 15:0 on the main port and bits 31:16 on the neighbour port in the same cycle. The two ports are consumed independently.
- R7: Mode 2'b11 behaves exactly like standard mode, including the write protection of the upper half.
- R8: While a valid output is high and its ready input is low, the valid stays high and the sample data stays unchanged.
- R9: A parallel-mode write that arrives while any sample is still waiting (either valid is high, or the second interleaved sample has not yet been issued) is dropped. The dropped write leaves the stored word and the pending samples untouched and sets `overrun`, which stays 1 until reset.
- R10: An accepted write makes its first sample visible in the cycle after the write clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Channel source select; 2'b10 selects parallel input |
| pack_mode | input | 2 | Packing mode: 00 standard, 01 interleaved, 10 dual, 11 as standard |
| wr_en | input | 1 | Write strobe for the sample word |
| wr_data | input | 32 | Write data; low sample in 15:0, high sample in 31:16 |
| wr_strb | input | 4 | Byte-lane write enables |
| smp_data | output | 16 | Signed sample to this channel's filter |
| smp_valid | output | 1 | Main sample valid |
| smp_ready | input | 1 | Main filter takes the sample |
| nb_data | output | 16 | Signed sample to the paired neighbour channel |
| nb_valid | output | 1 | Neighbour sample valid |
| nb_ready | input | 1 | Neighbour filter takes the sample |
| overrun | output | 1 | Sticky flag: a write was dropped because samples were pending |

## Verification
The bench writes the same kind of words under each packing mode, which separates a single-sample mode, a two-in-sequence mode and a split-across-ports mode. Partial-strobe interleaved writes are used as a probe: they expose the untouched lanes of the stored word. This shows whether a serial-mode write, a protected upper-half write, or a dropped overrun write leaked into storage. Holding ready low for several cycles, and releasing the two ready inputs at different times in dual mode, distinguishes proper hold-until-taken from a one-cycle pulse, and independent ports from ports that are wrongly coupled.

// File: rtl/psi_pkg.sv
package psi_pkg;
  typedef enum logic [1:0] {
    PK_STD  = 2'b00,
    PK_ILV  = 2'b01,
    PK_DUAL = 2'b10,
    PK_RSV  = 2'b11
  } pack_mode_e;

  localparam logic [1:0] SRC_PARALLEL = 2'b10;
endpackage

// File: rtl/psi_wr_merge.sv
module psi_wr_merge #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] old_word,
  input  logic [LANES*8-1:0] new_word,
  input  logic [LANES-1:0]   strb,
  input  logic [LANES-1:0]   lane_allow,
  output logic [LANES*8-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (strb[g] && lane_allow[g])
        merged[g*8 +: 8] = new_word[g*8 +: 8];
      else
        merged[g*8 +: 8] = old_word[g*8 +: 8];
    end
  end
endmodule

// File: rtl/psi_out_stage.sv
module psi_out_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= load | (valid & ~ready);
      if (load) data <= load_data;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data)));

  assert_no_clobber_R9: assert property (@(posedge clk) disable iff (rst)
    load |-> (!valid || ready));
endmodule

// File: rtl/par_sample_port.sv
module par_sample_port
  import psi_pkg::*;
#(
  parameter int SMP_W = 16,
  localparam int WORD_W = 2 * SMP_W,
  localparam int LANES = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        src_sel,
  input  logic [1:0]        pack_mode,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_strb,
  output logic [SMP_W-1:0]  smp_data,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [SMP_W-1:0]  nb_data,
  output logic              nb_valid,
  input  logic              nb_ready,
  output logic              overrun
);
  localparam int HALF_LANES = LANES / 2;

  pack_mode_e mode;
  logic parallel, is_std, busy, accept, drop, issue, second_go;
  logic pend1_q, overrun_q;
  logic [WORD_W-1:0] hold_q, merged;
  logic [LANES-1:0] lane_allow;
  logic main_load, nb_load;
  logic [SMP_W-1:0] main_load_data;

  assign mode     = pack_mode_e'(pack_mode);
  assign parallel = (src_sel == SRC_PARALLEL);
  assign is_std   = (mode == PK_STD) || (mode == PK_RSV);

  for (genvar g = 0; g < LANES; g++) begin : g_allow
    if (g < HALF_LANES) begin : g_low
      assign lane_allow[g] = 1'b1;
    end else begin : g_high
      assign lane_allow[g] = ~is_std;
    end
  end

  psi_wr_merge #(.LANES(LANES)) u_merge (
    .old_word  (hold_q),
    .new_word  (wr_data),
    .strb      (wr_strb),
    .lane_allow(lane_allow),
    .merged    (merged)
  );

  assign busy      = smp_valid | nb_valid | pend1_q;
  assign accept    = wr_en & parallel & ~busy;
  assign drop      = wr_en & parallel & busy;
  assign issue     = is_std ? |wr_strb[HALF_LANES-1:0] : |wr_strb;
  assign second_go = pend1_q & smp_valid & smp_ready;

  assign main_load      = (accept & issue) | second_go;
  assign main_load_data = second_go ? hold_q[WORD_W-1:SMP_W] : merged[SMP_W-1:0];
  assign nb_load        = accept & issue & (mode == PK_DUAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      pend1_q   <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (accept) hold_q <= merged;
      if (accept && issue && mode == PK_ILV) pend1_q <= 1'b1;
      else if (second_go)                    pend1_q <= 1'b0;
      if (drop) overrun_q <= 1'b1;
    end
  end

  psi_out_stage #(.W(SMP_W)) u_main (
    .clk(clk), .rst(rst), .load(main_load), .load_data(main_load_data),
    .ready(smp_ready), .valid(smp_valid), .data(smp_data)
  );

  psi_out_stage #(.W(SMP_W)) u_nb (
    .clk(clk), .rst(rst), .load(nb_load), .load_data(merged[WORD_W-1:SMP_W]),
    .ready(nb_ready), .valid(nb_valid), .data(nb_data)
  );

  assign overrun = overrun_q;

  assert_serial_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && src_sel != SRC_PARALLEL && !smp_valid && !nb_valid && !pend1_q)
      |=> (!smp_valid && !nb_valid));

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  assert_drop_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && src_sel == SRC_PARALLEL && (smp_valid || nb_valid)) |=> overrun);

  assert_nb_dual_only_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(nb_valid) |-> ($past(pack_mode) == 2'b10));

  assert_std_single_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && is_std) |=> !pend1_q);
endmodule

// File: tb/par_sample_port_bench.sv
module par_sample_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  src_sel = 2'b10;
  logic [1:0]  pack_mode = 2'b00;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_strb = '0;
  logic [15:0] smp_data, nb_data;
  logic        smp_valid, nb_valid, overrun;
  logic        smp_ready = 1'b0;
  logic        nb_ready = 1'b0;

  int ntests = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  par_sample_port u_par_sample_port (
    .clk(clk), .rst(rst), .src_sel(src_sel), .pack_mode(pack_mode),
    .wr_en(wr_en), .wr_data(wr_data), .wr_strb(wr_strb),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .nb_data(nb_data), .nb_valid(nb_valid), .nb_ready(nb_ready),
    .overrun(overrun)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d, logic [3:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_strb = s;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = '0;
  endtask

  task automatic pop_main();
    smp_ready = 1'b1;
    @(negedge clk);
    smp_ready = 1'b0;
  endtask

  task automatic pop_nb();
    nb_ready = 1'b1;
    @(negedge clk);
    nb_ready = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 smp_valid", smp_valid, 0);
    check("R1 nb_valid", nb_valid, 0);
    check("R1 overrun", overrun, 0);
    check("R1 smp_data", smp_data, 0);
    check("R1 nb_data", nb_data, 0);
  endtask

  task automatic t_standard();
    src_sel = 2'b10; pack_mode = 2'b00;
    wr(32'hAAAA_1234, 4'b1111);
    check("R10 valid after write", smp_valid, 1);
    check("R3 low sample", smp_data, 32'h1234);
    check("R3 no neighbour", nb_valid, 0);
    pop_main();
    check("R3 single sample", smp_valid, 0);
    pack_mode = 2'b01;
    wr(32'h0000_00FF, 4'b0001);
    check("R4 probe low", smp_data, 32'h12FF);
    pop_main();
    check("R3 upper protected", smp_data, 32'h0000);
    pop_main();
    pack_mode = 2'b00;
    wr(32'hFFFF_0000, 4'b1100);
    check("R3 upper-only no sample", smp_valid, 0);
  endtask

  task automatic t_hold();
    pack_mode = 2'b00;
    wr(32'h5555_BEEF, 4'b0011);
    repeat (3) @(negedge clk);
    check("R8 valid held", smp_valid, 1);
    check("R8 data held", smp_data, 32'hBEEF);
    pop_main();
    check("R8 consumed", smp_valid, 0);
  endtask

  task automatic t_serial();
    src_sel = 2'b00;
    wr(32'h9999_7777, 4'b1111);
    check("R2 no sample in serial", smp_valid, 0);
    src_sel = 2'b10; pack_mode = 2'b01;
    wr(32'h0000_0000, 4'b0001);
    check("R2 word untouched low", smp_data, 32'hBE00);
    pop_main();
    check("R2 word untouched high", smp_data, 32'h0000);
    pop_main();
  endtask

  task automatic t_interleaved();
    pack_mode = 2'b01;
    wr(32'hCAFE_8001, 4'b1111);
    check("R5 first sample", smp_data, 32'h8001);
    check("R5 neighbour idle", nb_valid, 0);
    pop_main();
    check("R5 second valid", smp_valid, 1);
    check("R5 second sample", smp_data, 32'hCAFE);
    pop_main();
    check("R5 done", smp_valid, 0);
  endtask

  task automatic t_strobes();
    pack_mode = 2'b01;
    wr(32'h1122_3344, 4'b1010);
    check("R4 low lanes", smp_data, 32'h3301);
    pop_main();
    check("R4 high lanes", smp_data, 32'h11FE);
    pop_main();
  endtask

  task automatic t_dual();
    pack_mode = 2'b10;
    wr(32'h7FFF_8000, 4'b1111);
    check("R6 main valid", smp_valid, 1);
    check("R6 main data", smp_data, 32'h8000);
    check("R6 nb valid", nb_valid, 1);
    check("R6 nb data", nb_data, 32'h7FFF);
    pop_nb();
    check("R6 nb consumed", nb_valid, 0);
    check("R6 main still valid", smp_valid, 1);
    pop_main();
    check("R6 main consumed", smp_valid, 0);
  endtask

  task automatic t_reserved();
    pack_mode = 2'b11;
    wr(32'hABCD_0042, 4'b1111);
    check("R7 sample", smp_data, 32'h0042);
    check("R7 nb idle", nb_valid, 0);
    pop_main();
    check("R7 single", smp_valid, 0);
    pack_mode = 2'b01;
    wr(32'h0000_0042, 4'b0001);
    pop_main();
    check("R7 upper protected", smp_data, 32'h7FFF);
    pop_main();
  endtask

  task automatic t_overrun();
    pack_mode = 2'b00;
    wr(32'h0000_1111, 4'b0011);
    check("R9 flag clear before", overrun, 0);
    wr(32'h0000_2222, 4'b0011);
    check("R9 overrun set", overrun, 1);
    check("R9 pending kept", smp_data, 32'h1111);
    pop_main();
    check("R9 dropped no sample", smp_valid, 0);
    pack_mode = 2'b01;
    wr(32'h0000_0000, 4'b0001);
    check("R9 word untouched", smp_data, 32'h1100);
    pop_main();
    pop_main();
    repeat (3) @(negedge clk);
    check("R9 sticky", overrun, 1);
  endtask

  initial begin
    t_reset();
    t_standard();
    t_hold();
    t_serial();
    t_interleaved();
    t_strobes();
    t_dual();
    t_reserved();
    t_overrun();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      ntests++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end
endmodule